// File: doc/BRIEF.md
# Prescaled Timer Counter with Event Flags

A free-running up-counter that advances on a tick from a power-of-two clock divider. A 3-bit select chooses the divisor. A change to that select is held back until the counter next rolls over to zero, so one count period never mixes two divisors. Beside the counter sits a small status unit. It keeps one sticky flag per capture/compare channel and one sticky overflow flag.

The capture and compare datapaths are not part of this block. Each channel is represented only by two things: event strobes that set its flag, and strobes that mark a read of its capture data or a write of its compare data. Software clears flags by writing ones. With the fast-clear control high, it can also clear a flag simply by touching that channel's data register.

The flag state is presented as two 8-bit register images. The channel flags occupy the low bits of one image. The overflow flag occupies the top bit of the other.

Top module: `tmr_flags`

## Requirements
- R1: After reset the count is 0, both register images read 0x00, the prescaler is cleared and the active divisor is 1.
- R2: While `en` is high, the count rises by exactly 1 once per completed divider period and wraps from all-ones to 0. While `en` is low, neither the count nor the divider moves.
- R3: The active select value n (0 to 7) gives a divider period of 2^n clock cycles: 1, 2, 4, 8, 16, 32, 64 or 128.
- R4: A new `psel` value is taken up only on the tick where the count rolls over to 0. Every increment before that rollover keeps the old period, and the first increment after it uses the new one.
- R5: A capture or compare strobe on channel i sets bit i of `chf_q` on the next clock edge. A flag that is already set neither blocks nor alters later events, and no flag rises without an event.
- R6: When `chf_wr` is high, each `chf_wdata` bit that is 1 clears the matching flag. Bits that are 0 leave their flags unchanged.
- R7: When `fast_clr` is high, `cap_rd[i]` or `cmp_wr[i]` clears flag i. When `fast_clr` is low, these strobes have no effect on the flags.
- R8: If a set and a clear (by write or by fast clear) reach the same flag in the same cycle, the flag ends up set. This holds for the overflow flag too.
- R9: The overflow flag is set on the tick where the count wraps to 0. It is cleared by `ovf_wr` with `ovf_wbit` equal to 1, and `ovf_wbit` equal to 0 leaves it alone.
- R10: `chf_q` carries channel i in bit i, and bits 7:4 read 0. `ovf_q` carries the overflow flag in bit 7, and bits 6:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Counter and divider run enable |
| psel | input | 3 | Requested divisor exponent |
| cap_evt | input | 4 | Per-channel capture event strobes |
| cmp_evt | input | 4 | Per-channel compare event strobes |
| fast_clr | input | 1 | Enables clear-on-data-access |
| cap_rd | input | 4 | Per-channel capture data read strobes |
| cmp_wr | input | 4 | Per-channel compare data write strobes |
| chf_wr | input | 1 | Write strobe for the channel flag image |
| chf_wdata | input | 4 | Write-one-to-clear mask for the channel flags |
| ovf_wr | input | 1 | Write strobe for the overflow image |
| ovf_wbit | input | 1 | Value written to the overflow bit (1 clears) |
| count | output | 16 | Current counter value |
| chf_q | output | 8 | Channel flag register image |
| ovf_q | output | 8 | Overflow flag register image |

## Verification
Two functions can land on the same flag in one cycle: setting it from an event or a rollover, and clearing it through a write-one or a fast-clear access. The bench provokes this on channel flags by driving an event together with a matching write mask, and separately together with a matching data access under fast clear. For the overflow flag, it waits until the count sits at all-ones and then issues the clearing write on the rollover edge. In each case the flag must read set on the following cycle. A behavioural model, which applies the clear before the set, must also agree on every cycle.

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int CNT_W = 16,
  parameter int NCH   = 4,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PS_W-1:0]  psel,
  input  logic [NCH-1:0]   cap_evt,
  input  logic [NCH-1:0]   cmp_evt,
  input  logic             fast_clr,
  input  logic [NCH-1:0]   cap_rd,
  input  logic [NCH-1:0]   cmp_wr,
  input  logic             chf_wr,
  input  logic [NCH-1:0]   chf_wdata,
  input  logic             ovf_wr,
  input  logic             ovf_wbit,
  output logic [CNT_W-1:0] count,
  output logic [7:0]       chf_q,
  output logic [7:0]       ovf_q
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q, div_lim;
  logic [PS_W-1:0]  act_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NCH-1:0]   flg_q, flg_set, flg_clr;
  logic             ovf_r, tick, wrap;

  assign div_lim = ~({DIV_W{1'b1}} << act_q);
  assign tick    = en & (div_q == div_lim);
  assign wrap    = tick & (&cnt_q);

  assign flg_set = cap_evt | cmp_evt;
  assign flg_clr = (chf_wr ? chf_wdata : '0) | (fast_clr ? (cap_rd | cmp_wr) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      act_q <= '0;
      cnt_q <= '0;
    end else begin
      if (en) div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) cnt_q <= cnt_q + 1'b1;
      if (wrap) act_q <= psel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      ovf_r <= 1'b0;
    end else begin
      flg_q <= (flg_q & ~flg_clr) | flg_set;
      ovf_r <= (ovf_r & ~(ovf_wr & ovf_wbit)) | wrap;
    end
  end

  assign count = cnt_q;
  assign chf_q = {{(8-NCH){1'b0}}, flg_q};
  assign ovf_q = {ovf_r, 7'b0};
endmodule

// File: rtl/tmr_flags_chk.sv
module tmr_flags_chk #(
  parameter int CNT_W = 16,
  parameter int NCH   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [NCH-1:0]   cap_evt,
  input logic [NCH-1:0]   cmp_evt,
  input logic [CNT_W-1:0] count,
  input logic [7:0]       chf_q,
  input logic [7:0]       ovf_q
);
  logic [NCH-1:0] evt;
  assign evt = cap_evt | cmp_evt;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1));

  assert_wrap_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (&count) |=> ((&count) || ovf_q[7]));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((chf_q[NCH-1:0] & $past(evt)) == $past(evt)));

  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((chf_q[NCH-1:0] & ~$past(chf_q[NCH-1:0]) & ~$past(evt)) == '0));

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (chf_q[7:NCH] == '0) && (ovf_q[6:0] == '0));
endmodule

bind tmr_flags tmr_flags_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cap_evt(cap_evt), .cmp_evt(cmp_evt),
  .count(count), .chf_q(chf_q), .ovf_q(ovf_q)
);

// File: tb/tb_tmr_flags.sv
`timescale 1ns/1ps
module tb_tmr_flags;
  localparam int CW   = 8;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, en = 0, fast_clr = 0, chf_wr = 0, ovf_wr = 0, ovf_wbit = 0;
  logic [2:0] psel = 0;
  logic [3:0] cap_evt = 0, cmp_evt = 0, cap_rd = 0, cmp_wr = 0, chf_wdata = 0;
  logic [CW-1:0] count;
  logic [7:0] chf_q, ovf_q;

  int checks = 0, errors = 0, cyc = 0;
  int m_cnt, m_div, m_act, m_chf, m_ovf;

  always #2 clk = ~clk;

  tmr_flags #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .psel(psel), .cap_evt(cap_evt), .cmp_evt(cmp_evt),
    .fast_clr(fast_clr), .cap_rd(cap_rd), .cmp_wr(cmp_wr), .chf_wr(chf_wr),
    .chf_wdata(chf_wdata), .ovf_wr(ovf_wr), .ovf_wbit(ovf_wbit),
    .count(count), .chf_q(chf_q), .ovf_q(ovf_q));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc++;

  // Reference model: clear applied first, then set; select taken at rollover.
  always @(posedge clk or negedge rst_n) begin
    int clr, evt;
    bit tk;
    if (!rst_n) begin
      m_cnt = 0; m_div = 0; m_act = 0; m_chf = 0; m_ovf = 0;
    end else begin
      tk = 0;
      if (en) begin
        m_div = m_div + 1;
        if (m_div == (1 << m_act)) begin m_div = 0; tk = 1; end
      end
      evt = int'(cap_evt | cmp_evt);
      clr = (chf_wr ? int'(chf_wdata) : 0) | (fast_clr ? int'(cap_rd | cmp_wr) : 0);
      m_chf = ((m_chf & ~clr) | evt) & 15;
      if (ovf_wr && ovf_wbit) m_ovf = 0;
      if (tk) begin
        if (m_cnt == MAXC) begin m_cnt = 0; m_ovf = 1; m_act = int'(psel); end
        else m_cnt = m_cnt + 1;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R2 model count", int'(count), m_cnt);
    chk("R5 R6 R7 model chf_q", int'(chf_q), m_chf);
    chk("R9 model ovf_q", int'(ovf_q), m_ovf << 7);
  end

  task automatic clr_in();
    cap_evt = 0; cmp_evt = 0; cap_rd = 0; cmp_wr = 0;
    chf_wr = 0; chf_wdata = 0; ovf_wr = 0; ovf_wbit = 0; fast_clr = 0;
  endtask

  task automatic nxt();
    @(negedge clk);
    clr_in();
  endtask

  task automatic interval(output int d);
    logic [CW-1:0] c0;
    int t0;
    c0 = count;
    while (count == c0) @(negedge clk);
    t0 = cyc; c0 = count;
    while (count == c0) @(negedge clk);
    d = cyc - t0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d, t0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 count", int'(count), 0);
    chk("R1 chf_q", int'(chf_q), 0);
    chk("R1 ovf_q", int'(ovf_q), 0);

    cap_evt = 4'b0001; cmp_evt = 4'b0100; nxt();
    chk("R5 set two channels", int'(chf_q), 5);
    cap_evt = 4'b0001; nxt();
    chk("R5 event on set flag", int'(chf_q), 5);
    chf_wr = 1; chf_wdata = 0; nxt();
    chk("R6 write zero", int'(chf_q), 5);
    chf_wr = 1; chf_wdata = 4'b0001; nxt();
    chk("R6 write one clears", int'(chf_q), 4);
    fast_clr = 0; cmp_wr = 4'b0100; cap_rd = 4'b0100; nxt();
    chk("R7 access without fast clear", int'(chf_q), 4);
    fast_clr = 1; cmp_wr = 4'b0100; nxt();
    chk("R7 compare write clears", int'(chf_q), 0);
    cap_evt = 4'b1010; nxt();
    fast_clr = 1; cap_rd = 4'b0010; nxt();
    chk("R7 capture read clears", int'(chf_q), 8);
    chf_wr = 1; chf_wdata = 4'b1000; cmp_evt = 4'b1000; nxt();
    chk("R8 event beats write clear", int'(chf_q), 8);
    fast_clr = 1; cap_rd = 4'b0001; cap_evt = 4'b0001; nxt();
    chk("R8 event beats fast clear", int'(chf_q), 9);
    chk("R10 reserved bits", int'(chf_q[7:4]), 0);

    en = 1;
    repeat (MAXC + 4) @(negedge clk);
    chk("R9 overflow set", int'(ovf_q), 128);
    chk("R10 overflow reserved bits", int'(ovf_q[6:0]), 0);
    ovf_wr = 1; ovf_wbit = 0; nxt();
    chk("R9 write zero keeps", int'(ovf_q), 128);
    ovf_wr = 1; ovf_wbit = 1; nxt();
    chk("R9 write one clears", int'(ovf_q), 0);
    while (count != MAXC[CW-1:0]) @(negedge clk);
    ovf_wr = 1; ovf_wbit = 1; nxt();
    chk("R8 wrap beats overflow clear", int'(ovf_q), 128);

    en = 0; t0 = int'(count);
    repeat (20) @(negedge clk);
    chk("R2 hold while disabled", int'(count), t0);
    en = 1;
    while (count != 0) @(negedge clk);
    while (count != 5) @(negedge clk);

    for (int n = 1; n < 8; n++) begin
      psel = 3'(n);
      interval(d);
      chk("R4 old period kept", d, 1 << (n - 1));
      while (count != 0) @(negedge clk);
      t0 = cyc;
      while (count != 1) @(negedge clk);
      chk("R3 R4 new period after wrap", cyc - t0, 1 << n);
    end

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule